// File: doc/BRIEF.md
# NAND Page Read Controller

This block reads a single page from a small-page NAND flash with an 8-bit bus and hands the bytes, one at a time, to a downstream consumer. A command port supplies the page address, made of an 11-bit erase-block number and a 5-bit page number, together with a limit on how long the block may wait for the flash to become ready. The block then drives the read sequence onto the flash bus. First comes a command-latch cycle carrying opcode 0x00. Three address-latch cycles follow: a column byte of 0x00, the low row byte, then the high row byte. The block waits on the ready/busy line and then pulses read-enable once per byte.

A page holds 528 bytes: two 256-byte data halves followed by 16 spare bytes. Every byte leaves the block with its position in the page and a flag that marks it as spare data. The output is a valid/ready handshake. While the consumer refuses a byte, the next read-enable pulse is held back, so backpressure never drops data. A one-cycle done pulse closes a good read. If the ready line does not come back within the limit, an error pulse closes the read instead. In both cases chip enable is released.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, and after any reset during a transfer, cmdReady is 1, outValid, done and error are 0, nandCeN, nandWeN and nandReN are 1, and nandCle and nandAle are 0.
- R2: An accepted command produces exactly one command-latch write of 0x00 followed by three address-latch writes in this order: column 0x00, row low byte, row high byte. Each is latched on the rising edge of nandWeN.
- R3: The 16-bit row is {cmdBlock, cmdPage}. The row low byte is {cmdBlock[2:0], cmdPage[4:0]} and the row high byte is cmdBlock[10:3].
- R4: After the address writes, nandReN does not fall while the ready/busy input is low.
- R5: A good read delivers exactly 528 handshakes. Their outIndex values run 0 to 527 in order, and outData is the flash byte at that column.
- R6: outSpare is 1 for outIndex 512 to 527 and 0 for outIndex 0 to 511.
- R7: While outValid is 1 and outReady is 0, outValid, outData and outIndex stay unchanged, and no byte is skipped.
- R8: Each nandReN low pulse lasts at least RE_LOW clock cycles, and each high phase between pulses lasts at least RE_HIGH cycles.
- R9: done pulses for one cycle exactly two cycles after the handshake of byte 527. At that pulse nandCeN is 1, and the block then accepts a new command.
- R10: If ready stays low for more than cmdTimeout cycles of waiting, error pulses, no byte is delivered, done stays 0 and nandCeN returns to 1.
- R11: With nandCle high, the only value ever written is 0x00, so no program or erase opcode is ever issued.
- R12: nandCle and nandAle are never high together, and nandWeN and nandReN are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Page read request |
| cmdReady | output | 1 | Block idle, request accepted this cycle |
| cmdBlock | input | 11 | Erase-block number |
| cmdPage | input | 5 | Page number within the block |
| cmdTimeout | input | 16 | Maximum ready wait, in cycles |
| outValid | output | 1 | Byte available |
| outReady | input | 1 | Consumer takes the byte |
| outData | output | 8 | Page byte |
| outIndex | output | 10 | Byte position in the page, 0 to 527 |
| outSpare | output | 1 | Byte lies in the spare area |
| done | output | 1 | One-cycle pulse, page complete |
| error | output | 1 | One-cycle pulse, ready wait timed out |
| nandCeN | output | 1 | Flash chip enable, active low |
| nandCle | output | 1 | Flash command latch enable |
| nandAle | output | 1 | Flash address latch enable |
| nandWeN | output | 1 | Flash write enable, active low |
| nandReN | output | 1 | Flash read enable, active low |
| nandDout | output | 8 | Byte driven onto the flash bus |
| nandDoutEn | output | 1 | Flash bus drive enable |
| nandDin | input | 8 | Byte read from the flash bus |
| nandRdy | input | 1 | Flash ready/busy, high when ready |

## Verification
Two situations are the hardest to reach from the ports. The first is a consumer that holds off while a byte waits, which has to coincide with every phase of the read-enable cycle. The bench covers this with consumer patterns that change per vector: always ready, alternate cycles, one cycle in eight, and a pseudo-random sequence. Each pattern walks all 528 bytes. The second is the timeout path. It needs the flash model to stay busy longer than the programmed limit, and one vector pairs a long busy time with a short limit. A reset is also forced partway through a page, followed by a fresh read that must complete.

// File: rtl/nandrd_pkg.sv
package nandrd_pkg;

  // Strobes from the sequencer to the datapath, one set per cycle.
  typedef struct packed {
    logic       ceOn;
    logic       cleOn;
    logic       aleOn;
    logic       weLow;
    logic       reLow;
    logic       busOut;
    logic       loadCmd;
    logic       capture;
    logic       timerRun;
    logic       doneS;
    logic       errS;
    logic [1:0] byteSel;
  } nandStrobes_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WR_SETUP, ST_WR_LOW, ST_WR_HOLD, ST_WAIT_TWB, ST_WAIT_RDY,
    ST_RD_LOW, ST_RD_CAP, ST_RD_HOLD, ST_RD_HIGH, ST_FIN, ST_FAIL
  } rdState_t;

  localparam logic [7:0] READ_OPCODE = 8'h00;
  localparam logic [7:0] COLUMN_ZERO = 8'h00;

endpackage

// File: rtl/nandrd_ctrl.sv
module nandrd_ctrl
  import nandrd_pkg::*;
#(
  parameter int WE_LOW  = 2,
  parameter int WE_HIGH = 2,
  parameter int RE_LOW  = 2,
  parameter int RE_HIGH = 2,
  parameter int TWB     = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         rdySync,
  input  logic         timedOut,
  input  logic         taken,
  input  logic         lastByte,
  output logic         cmdReady,
  output nandStrobes_t strobe
);

  localparam int M1    = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
  localparam int M2    = (RE_LOW > RE_HIGH) ? RE_LOW : RE_HIGH;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int MAXP  = (M3 > TWB) ? M3 : TWB;
  localparam int CNT_W = $clog2(MAXP + 1) + 1;

  rdState_t         state;
  logic [CNT_W-1:0] phase;
  logic [1:0]       sel;
  logic             inWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
      sel   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          phase <= '0;
          sel   <= '0;
          if (cmdValid) state <= ST_WR_SETUP;
        end
        ST_WR_SETUP: begin
          phase <= '0;
          state <= ST_WR_LOW;
        end
        ST_WR_LOW: begin
          if (phase == CNT_W'(WE_LOW - 1)) begin
            phase <= '0;
            state <= ST_WR_HOLD;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_WR_HOLD: begin
          if (phase == CNT_W'(WE_HIGH - 1)) begin
            phase <= '0;
            if (sel == 2'd3) begin
              state <= ST_WAIT_TWB;
            end else begin
              sel   <= sel + 1'b1;
              state <= ST_WR_SETUP;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_WAIT_TWB: begin
          if (phase == CNT_W'(TWB - 1)) begin
            phase <= '0;
            state <= ST_WAIT_RDY;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_WAIT_RDY: begin
          phase <= '0;
          if (rdySync)       state <= ST_RD_LOW;
          else if (timedOut) state <= ST_FAIL;
        end
        ST_RD_LOW: begin
          if (phase == CNT_W'(RE_LOW - 1)) begin
            phase <= '0;
            state <= ST_RD_CAP;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_RD_CAP: state <= ST_RD_HOLD;
        ST_RD_HOLD: begin
          phase <= '0;
          if (taken) state <= lastByte ? ST_FIN : ST_RD_HIGH;
        end
        ST_RD_HIGH: begin
          if (phase == CNT_W'(RE_HIGH - 1)) begin
            phase <= '0;
            state <= ST_RD_LOW;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        ST_FAIL: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign inWrite  = (state == ST_WR_SETUP) || (state == ST_WR_LOW) || (state == ST_WR_HOLD);
  assign cmdReady = (state == ST_IDLE);

  always_comb begin
    strobe          = '0;
    strobe.ceOn     = (state != ST_IDLE) && (state != ST_FIN) && (state != ST_FAIL);
    strobe.cleOn    = inWrite && (sel == 2'd0);
    strobe.aleOn    = inWrite && (sel != 2'd0);
    strobe.busOut   = inWrite;
    strobe.weLow    = (state == ST_WR_LOW);
    strobe.reLow    = (state == ST_RD_LOW);
    strobe.capture  = (state == ST_RD_CAP);
    strobe.timerRun = (state == ST_WAIT_RDY);
    strobe.loadCmd  = (state == ST_IDLE) && cmdValid;
    strobe.doneS    = (state == ST_FIN);
    strobe.errS     = (state == ST_FAIL);
    strobe.byteSel  = sel;
  end

endmodule

// File: rtl/nandrd_dp.sv
module nandrd_dp
  import nandrd_pkg::*;
#(
  parameter int BLOCK_W    = 11,
  parameter int PAGE_W     = 5,
  parameter int TMO_W      = 16,
  parameter int PAGE_BYTES = 528,
  parameter int MAIN_BYTES = 512,
  parameter int IDX_W      = $clog2(PAGE_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  nandStrobes_t       strobe,
  input  logic [BLOCK_W-1:0] cmdBlock,
  input  logic [PAGE_W-1:0]  cmdPage,
  input  logic [TMO_W-1:0]   cmdTimeout,
  input  logic [7:0]         nandDin,
  input  logic               nandRdy,
  input  logic               outReady,
  output logic               outValid,
  output logic [7:0]         outData,
  output logic [IDX_W-1:0]   outIndex,
  output logic               outSpare,
  output logic               done,
  output logic               error,
  output logic               nandCeN,
  output logic               nandCle,
  output logic               nandAle,
  output logic               nandWeN,
  output logic               nandReN,
  output logic [7:0]         nandDout,
  output logic               nandDoutEn,
  output logic               rdySync,
  output logic               timedOut,
  output logic               taken,
  output logic               lastByte
);

  localparam int ROW_W = BLOCK_W + PAGE_W;

  logic [ROW_W-1:0] rowR;
  logic [15:0]      rowPad;
  logic [TMO_W-1:0] limitR;
  logic [TMO_W-1:0] waitCnt;
  logic [IDX_W-1:0] idx;
  logic [7:0]       busByte;

  assign rowPad   = 16'(rowR);
  assign taken    = outValid && outReady;
  assign lastByte = (idx == IDX_W'(PAGE_BYTES - 1));
  assign timedOut = (waitCnt >= limitR);
  assign outIndex = idx;
  assign outSpare = (idx >= IDX_W'(MAIN_BYTES));

  always_comb begin
    case (strobe.byteSel)
      2'd0:    busByte = READ_OPCODE;
      2'd1:    busByte = COLUMN_ZERO;
      2'd2:    busByte = rowPad[7:0];
      default: busByte = rowPad[15:8];
    endcase
  end

  // Request registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowR   <= '0;
      limitR <= '0;
    end else if (strobe.loadCmd) begin
      rowR   <= {cmdBlock, cmdPage};
      limitR <= cmdTimeout;
    end
  end

  // Ready wait timer, saturating
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.timerRun) waitCnt <= '0;
    else if (waitCnt != '1)        waitCnt <= waitCnt + 1'b1;
  end

  // Registered flash pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nandCeN    <= 1'b1;
      nandCle    <= 1'b0;
      nandAle    <= 1'b0;
      nandWeN    <= 1'b1;
      nandReN    <= 1'b1;
      nandDout   <= '0;
      nandDoutEn <= 1'b0;
      rdySync    <= 1'b0;
    end else begin
      nandCeN    <= !strobe.ceOn;
      nandCle    <= strobe.cleOn;
      nandAle    <= strobe.aleOn;
      nandWeN    <= !strobe.weLow;
      nandReN    <= !strobe.reLow;
      nandDout   <= strobe.busOut ? busByte : '0;
      nandDoutEn <= strobe.busOut;
      rdySync    <= nandRdy;
    end
  end

  // Output byte register and page position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      idx      <= '0;
    end else begin
      if (strobe.loadCmd) begin
        outValid <= 1'b0;
        idx      <= '0;
      end else if (strobe.capture) begin
        outValid <= 1'b1;
        outData  <= nandDin;
      end else if (taken) begin
        outValid <= 1'b0;
        idx      <= idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      done  <= strobe.doneS;
      error <= strobe.errS;
    end
  end

endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nandrd_pkg::*;
#(
  parameter int BLOCK_W    = 11,
  parameter int PAGE_W     = 5,
  parameter int TMO_W      = 16,
  parameter int PAGE_BYTES = 528,
  parameter int MAIN_BYTES = 512,
  parameter int WE_LOW     = 2,
  parameter int WE_HIGH    = 2,
  parameter int RE_LOW     = 2,
  parameter int RE_HIGH    = 2,
  parameter int TWB        = 4,
  parameter int IDX_W      = $clog2(PAGE_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [BLOCK_W-1:0] cmdBlock,
  input  logic [PAGE_W-1:0]  cmdPage,
  input  logic [TMO_W-1:0]   cmdTimeout,
  output logic               outValid,
  input  logic               outReady,
  output logic [7:0]         outData,
  output logic [IDX_W-1:0]   outIndex,
  output logic               outSpare,
  output logic               done,
  output logic               error,
  output logic               nandCeN,
  output logic               nandCle,
  output logic               nandAle,
  output logic               nandWeN,
  output logic               nandReN,
  output logic [7:0]         nandDout,
  output logic               nandDoutEn,
  input  logic [7:0]         nandDin,
  input  logic               nandRdy
);

  nandStrobes_t strobe;
  logic rdySync, timedOut, taken, lastByte;

  nandrd_ctrl #(
    .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RE_LOW(RE_LOW),
    .RE_HIGH(RE_HIGH), .TWB(TWB)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .rdySync(rdySync),
    .timedOut(timedOut), .taken(taken), .lastByte(lastByte),
    .cmdReady(cmdReady), .strobe(strobe)
  );

  nandrd_dp #(
    .BLOCK_W(BLOCK_W), .PAGE_W(PAGE_W), .TMO_W(TMO_W),
    .PAGE_BYTES(PAGE_BYTES), .MAIN_BYTES(MAIN_BYTES), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdBlock(cmdBlock), .cmdPage(cmdPage), .cmdTimeout(cmdTimeout),
    .nandDin(nandDin), .nandRdy(nandRdy), .outReady(outReady),
    .outValid(outValid), .outData(outData), .outIndex(outIndex),
    .outSpare(outSpare), .done(done), .error(error),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDout(nandDout),
    .nandDoutEn(nandDoutEn), .rdySync(rdySync), .timedOut(timedOut),
    .taken(taken), .lastByte(lastByte)
  );

endmodule

// File: rtl/nandrd_checker.sv
module nandrd_checker #(
  parameter int PAGE_BYTES = 528,
  parameter int RE_LOW     = 2,
  parameter int IDX_W      = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             outValid,
  input logic             outReady,
  input logic [7:0]       outData,
  input logic [IDX_W-1:0] outIndex,
  input logic             done,
  input logic             error,
  input logic             nandCeN,
  input logic             nandCle,
  input logic             nandAle,
  input logic             nandWeN,
  input logic             nandReN,
  input logic [7:0]       nandDout
);

  logic [7:0] reLowCnt;

  always_ff @(posedge clk) begin
    if (!rstN || nandReN)   reLowCnt <= '0;
    else if (reLowCnt != '1) reLowCnt <= reLowCnt + 1'b1;
  end

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outIndex)));

  p_index_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outIndex < IDX_W'(PAGE_BYTES)));

  p_latch_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  p_read_opcode_only_r11: assert property (@(posedge clk) disable iff (!rstN)
    (nandCle && !nandWeN) |-> (nandDout == 8'h00));

  p_re_low_width_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandReN) |-> (reLowCnt >= 8'(RE_LOW)));

  p_done_releases_ce_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (nandCeN && !error));

  p_error_clean_r10: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (nandCeN && !outValid));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind nand_page_reader nandrd_checker #(
  .PAGE_BYTES(PAGE_BYTES), .RE_LOW(RE_LOW), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outIndex(outIndex), .done(done), .error(error),
  .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
  .nandWeN(nandWeN), .nandReN(nandReN), .nandDout(nandDout)
);

// File: tb/tb_nand_page_reader.sv
`timescale 1ns/1ps
module tb_nand_page_reader;

  localparam int RE_LOW  = 2;
  localparam int RE_HIGH = 2;
  localparam int NVEC    = 5;

  // {block[10:0], page[4:0], busy[15:0], limit[15:0], stall[1:0], expErr}
  localparam logic [50:0] VECS [NVEC] = '{
    {11'd0,    5'd0,  16'd10,  16'd200, 2'd0, 1'b0},
    {11'd2047, 5'd31, 16'd30,  16'd200, 2'd1, 1'b0},
    {11'd1445, 5'd19, 16'd5,   16'd200, 2'd2, 1'b0},
    {11'd3,    5'd7,  16'd100, 16'd40,  2'd0, 1'b1},
    {11'd1024, 5'd1,  16'd20,  16'd60,  2'd3, 1'b0}
  };

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, outReady = 0;
  logic [10:0] cmdBlock = '0;
  logic [4:0]  cmdPage = '0;
  logic [15:0] cmdTimeout = '0;
  logic cmdReady, outValid, outSpare, done, error;
  logic [7:0] outData, nandDout, nandDin;
  logic [9:0] outIndex;
  logic nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDoutEn;
  logic nandRdy;

  nand_page_reader dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdBlock(cmdBlock), .cmdPage(cmdPage), .cmdTimeout(cmdTimeout),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outIndex(outIndex), .outSpare(outSpare), .done(done), .error(error),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDout(nandDout),
    .nandDoutEn(nandDoutEn), .nandDin(nandDin), .nandRdy(nandRdy)
  );

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] flashByte(input int blk, input int pg, input int col);
    return 8'((col * 7) ^ blk ^ (pg << 3) ^ (col >> 8));
  endfunction

  // ---------------- flash model ----------------
  int   modelBusy = 10;
  logic weQ = 1, reQ = 1;
  logic [7:0] cmdSeen, colByte, rowLo, rowHi;
  int   addrCnt = 0, busyLeft = 0, colPtr = 0;
  int   badCmd = 0, overlap = 0, reViol = 0, reWhileBusy = 0;
  int   reLowRun = 0, reHighRun = 100;

  assign nandDin = flashByte({rowHi, rowLo[7:5]}, rowLo[4:0], colPtr);

  always @(posedge clk) begin
    weQ <= nandWeN;
    reQ <= nandReN;
    if (!rstN) begin
      nandRdy  <= 1'b1;
      busyLeft = 0;
    end else begin
      if (nandWeN && !weQ && !nandCeN) begin
        if (nandCle) begin
          cmdSeen = nandDout;
          if (nandDout != 8'h00) badCmd++;
          addrCnt = 0;
          colPtr  = 0;
        end else if (nandAle) begin
          case (addrCnt)
            0: colByte = nandDout;
            1: rowLo   = nandDout;
            default: rowHi = nandDout;
          endcase
          if (addrCnt == 2) begin
            busyLeft = modelBusy;
            nandRdy <= 1'b0;
          end
          addrCnt++;
        end
      end else if (busyLeft != 0) begin
        if (busyLeft == 1) nandRdy <= 1'b1;
        busyLeft--;
      end
      if (!nandReN && reQ) begin
        if (!nandRdy) reWhileBusy++;
        if (reHighRun < RE_HIGH) reViol++;
      end
      if (nandReN && !reQ) begin
        colPtr++;
        if (reLowRun < RE_LOW) reViol++;
      end
      if (!nandReN) begin reLowRun++; reHighRun = 0; end
      else begin reHighRun++; reLowRun = 0; end
      if (nandCle && nandAle) overlap++;
      if (!nandWeN && !nandReN) overlap++;
    end
  end

  // ---------------- consumer ----------------
  int curBlock = 0, curPage = 0, stallMode = 0;
  int rxCount = 0, doneSeen = 0, errSeen = 0, negCyc = 0, lastRxCyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit   prevStall = 0;
  logic [7:0] prevData;
  logic [9:0] prevIdx;

  always @(negedge clk) begin
    negCyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rstN) begin
      if (prevStall) begin
        // R7: a refused byte stays put
        check(outValid && outData == prevData && outIndex == prevIdx,
              "R7 held byte", int'(outData), int'(prevData));
      end
      case (stallMode)
        0: outReady = 1'b1;
        1: outReady = negCyc[0];
        2: outReady = (negCyc[2:0] == 3'd0);
        default: outReady = lfsr[0];
      endcase
      prevStall = outValid && !outReady;
      prevData  = outData;
      prevIdx   = outIndex;
      if (outValid && outReady) begin
        check(outIndex == 10'(rxCount), "R5 index order", int'(outIndex), rxCount);
        check(outData == flashByte(curBlock, curPage, rxCount), "R5 data",
              int'(outData), int'(flashByte(curBlock, curPage, rxCount)));
        check(outSpare == (rxCount >= 512), "R6 spare flag",
              int'(outSpare), int'(rxCount >= 512));
        rxCount++;
        lastRxCyc = negCyc;
      end
      if (done) begin
        doneSeen++;
        check(negCyc - lastRxCyc == 2, "R9 done timing", negCyc - lastRxCyc, 2);
        check(nandCeN == 1'b1, "R9 ce released at done", int'(nandCeN), 1);
      end
      if (error) errSeen++;
    end else begin
      prevStall = 0;
      outReady  = 1'b0;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(negedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic checkIdle(input string tag);
    check(cmdReady == 1'b1, {tag, " cmdReady"}, int'(cmdReady), 1);
    check(outValid == 1'b0, {tag, " outValid"}, int'(outValid), 0);
    check(nandCeN && nandWeN && nandReN, {tag, " strobes idle"},
          int'({nandCeN, nandWeN, nandReN}), 7);
    check(!nandCle && !nandAle && !done && !error, {tag, " latches/pulses low"},
          int'({nandCle, nandAle, done, error}), 0);
  endtask

  task automatic runVector(input int v);
    logic [50:0] f;
    bit expErr;
    f = VECS[v];
    curBlock  = int'(f[50:40]);
    curPage   = int'(f[39:35]);
    modelBusy = int'(f[34:19]);
    stallMode = int'(f[2:1]);
    expErr    = f[0];
    rxCount = 0; doneSeen = 0; errSeen = 0;
    badCmd = 0; overlap = 0; reViol = 0; reWhileBusy = 0;
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdBlock   = f[50:40];
    cmdPage    = f[39:35];
    cmdTimeout = f[18:3];
    cmdValid   = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int k = 0; k < 30000 && doneSeen == 0 && errSeen == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(cmdSeen == 8'h00 && colByte == 8'h00, "R2 opcode and column",
          int'({cmdSeen, colByte}), 0);
    check(rowLo == {f[42:40], f[39:35]}, "R3 row low byte", int'(rowLo),
          int'({f[42:40], f[39:35]}));
    check(rowHi == f[50:43], "R3 row high byte", int'(rowHi), int'(f[50:43]));
    check(badCmd == 0, "R11 non-read opcode", badCmd, 0);
    check(overlap == 0, "R12 bus overlap", overlap, 0);
    check(reViol == 0, "R8 read strobe width", reViol, 0);
    check(reWhileBusy == 0, "R4 read while busy", reWhileBusy, 0);
    check(errSeen == int'(expErr), "R10 error pulse", errSeen, int'(expErr));
    check(rxCount == (expErr ? 0 : 528), "R5 byte count", rxCount, expErr ? 0 : 528);
    check(doneSeen == (expErr ? 0 : 1), "R9 done count", doneSeen, expErr ? 0 : 1);
    check(nandCeN == 1'b1 && cmdReady == 1'b1, "R10 back to idle",
          int'({nandCeN, cmdReady}), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after release");
    for (int v = 0; v < NVEC; v++) runVector(v);

    // R1: reset partway through a page, then a clean read
    curBlock = 77; curPage = 9; stallMode = 0; modelBusy = 8; rxCount = 0;
    cmdBlock = 11'd77; cmdPage = 5'd9; cmdTimeout = 16'd100;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int k = 0; k < 5000 && rxCount < 40; k++) @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkIdle("R1 mid-transfer reset");
    rstN = 1'b1;
    runVector(0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule